// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block controls one successive-approximation conversion of an on-chip 10-bit converter. The analog capacitor array and the comparator lie outside it. The comparator reaches the block as a single digital decision bit. The block drives the trial code that the comparator is measured against. A one-cycle strobe on the start input requests a conversion. That strobe stands in for the CPU writing to the low result register, and it carries no data. The request is held until the next machine-cycle boundary, which comes from a free-running counter of `MCYC_LEN` clocks. The conversion then starts.

Each conversion runs three phases. A sampling phase comes first, then a conversion phase in which the result is resolved one bit per window, MSB first. Last comes a single-clock write-back phase in which the result register is loaded. The `div_sel_i` input picks one of two time scales. With `div_sel_i = 0` a window is 4 clocks, with `div_sel_i = 1` it is 8 clocks. The sampling phase lasts 2 windows and the conversion phase lasts 10 windows. Busy is high through sampling and conversion only. The interrupt flag is set on the same edge that drops busy, and it stays set until software clears it.

The result and the flags are held registers read by software, not a data stream. For that reason there is no valid/ready handshake at the edge of the block. A new start strobe during a running conversion throws that conversion away and queues a fresh one.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Sampling begins, and `busy_o` rises, on a machine-cycle boundary strictly after the start strobe. Counted in clock samples from the strobe cycle, `busy_o` is first seen high between 2 and `MCYC_LEN`+1 samples later.
- R2: With `div_sel_i = 0` (windows of 4 clocks), `busy_o` stays high for exactly 48 consecutive clocks: 8 for sampling and 40 for conversion.
- R3: With `div_sel_i = 1` (windows of 8 clocks), `busy_o` stays high for exactly 96 consecutive clocks: 16 for sampling and 80 for conversion.
- R4: The conversion phase makes 10 decisions, from bit 9 down to bit 0, one at the last clock of each window. When a decision is made, `trial_o` holds the decided bits with the bit under test set to 1. A comparator input of 1 keeps that bit. With an ideal comparator (`cmp_i` = input code ≥ `trial_o`), the result equals the input code.
- R5: `irq_o` rises on the same clock edge on which `busy_o` falls. `result_o` takes the new code one clock later, at the end of the write-back phase.
- R6: A start strobe while `busy_o` is high drops `busy_o` on the next edge. The aborted conversion neither sets `irq_o` nor changes `result_o`. A new full-length conversion starts at a later boundary.
- R7: `irq_o` stays high until a cycle with `irq_clr_i` high. If a clear and a set fall in the same cycle, the flag ends up set.
- R8: A change of `div_sel_i` while `busy_o` is high does not alter the length of the running conversion. The selection is sampled when sampling begins.
- R9: After reset, `busy_o`, `irq_o`, `trial_o` and `result_o` are 0. `result_o` changes only at the end of a write-back phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter input clock; one period per time slot |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_wr_i | input | 1 | One-cycle start request (low result register write) |
| div_sel_i | input | 1 | Time scale: 0 = 4-clock windows, 1 = 8-clock windows |
| cmp_i | input | 1 | Comparator decision: 1 when the sampled input ≥ trial code |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| busy_o | output | 1 | High during sampling and conversion |
| irq_o | output | 1 | Sticky conversion-complete flag |
| trial_o | output | 10 | Trial code presented to the comparator |
| result_o | output | 10 | Last completed conversion result |

## Verification
A slot counter that is off by one shows at once as a busy pulse of the wrong length. A wrongly latched time scale shows as a busy pulse of the other family's length. Both are visible when busy falls, within one conversion. A broken approximation step or a bad pointer shows up one clock after busy falls, as a result that differs from the stimulus code. Abort faults show within a single clock of the restart strobe, as busy staying high. They also show at the end of the aborted run, as a spurious interrupt or a result that changed.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_CONV   = 2'd2,
    PH_WRITE  = 2'd3
  } phase_e;
endpackage

// File: rtl/adc_mcyc_timer.sv
module adc_mcyc_timer #(
  parameter int MCYC_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic boundary_o
);
  localparam int CW = (MCYC_LEN > 1) ? $clog2(MCYC_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(MCYC_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign boundary_o = (cnt_q == LAST);
endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
  import adc_seq_pkg::*;
#(
  parameter int BITS        = 10,
  parameter int SAMPLE_MULT = 2,
  parameter int CONV_MULT   = 10,
  parameter int BASE_LOG2   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic boundary_i,
  input  logic div_sel_i,
  output logic busy_o,
  output logic sar_load_o,
  output logic sar_dec_o,
  output logic irq_set_o,
  output logic write_o
);
  localparam int MAX_SCALE = 2 << BASE_LOG2;
  localparam int SLOT_W    = $clog2(CONV_MULT * MAX_SCALE + 1);

  phase_e            state_q;
  logic [SLOT_W-1:0] slot_q;
  logic              pend_q;
  logic              scale8_q;

  logic [SLOT_W-1:0] scale_w, mask_w, sample_len, conv_len, dec_span, phase_len;
  logic              last_slot;

  assign scale_w    = scale8_q ? SLOT_W'(MAX_SCALE) : SLOT_W'(MAX_SCALE / 2);
  assign mask_w     = scale_w - 1'b1;
  assign sample_len = SLOT_W'(SAMPLE_MULT) * scale_w;
  assign conv_len   = SLOT_W'(CONV_MULT) * scale_w;
  assign dec_span   = SLOT_W'(BITS) * scale_w;
  assign phase_len  = (state_q == PH_SAMPLE) ? sample_len : conv_len;
  assign last_slot  = (slot_q == phase_len - 1'b1);

  assign busy_o     = (state_q == PH_SAMPLE) || (state_q == PH_CONV);
  assign write_o    = (state_q == PH_WRITE);
  assign sar_load_o = (state_q == PH_SAMPLE) && last_slot && !start_i;
  assign sar_dec_o  = (state_q == PH_CONV) && ((slot_q & mask_w) == mask_w) &&
                      (slot_q < dec_span) && !start_i;
  assign irq_set_o  = (state_q == PH_CONV) && last_slot && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PH_IDLE;
      slot_q   <= '0;
      pend_q   <= 1'b0;
      scale8_q <= 1'b0;
    end else begin
      pend_q <= pend_q | start_i;
      unique case (state_q)
        PH_IDLE: begin
          if (pend_q && boundary_i) begin
            state_q  <= PH_SAMPLE;
            slot_q   <= '0;
            pend_q   <= 1'b0;
            scale8_q <= div_sel_i;
          end
        end
        PH_SAMPLE, PH_CONV: begin
          if (start_i) begin
            state_q <= PH_IDLE;
            slot_q  <= '0;
          end else if (last_slot) begin
            state_q <= (state_q == PH_SAMPLE) ? PH_CONV : PH_WRITE;
            slot_q  <= '0;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        PH_WRITE: begin
          state_q <= PH_IDLE;
          slot_q  <= '0;
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  AST_LAUNCH_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_SAMPLE && $past(state_q) == PH_IDLE) |-> $past(boundary_i) && $past(pend_q)); // R1
  AST_WRITE_FOLLOWS_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_WRITE) |-> ($past(state_q) == PH_CONV) && !$past(start_i)); // R5
  AST_ABORT_DROPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !busy_o); // R6
  AST_SCALE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(scale8_q)); // R8
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int BITS = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            dec_i,
  input  logic            cmp_i,
  output logic [BITS-1:0] code_o
);
  logic [BITS-1:0] code_q;
  logic [BITS-1:0] ptr_q;
  logic [BITS-1:0] ptr_nxt;

  assign ptr_nxt = ptr_q >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= {1'b1, {(BITS-1){1'b0}}};
    else if (dec_i)  ptr_q <= ptr_nxt;
  end

  for (genvar g = 0; g < BITS; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     code_q[g] <= 1'b0;
      else if (load_i) code_q[g] <= (g == BITS - 1);
      else if (dec_i) begin
        if (ptr_q[g])        code_q[g] <= cmp_i;
        else if (ptr_nxt[g]) code_q[g] <= 1'b1;
      end
    end
  end

  assign code_o = code_q;

  AST_DECIDE_WHILE_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (ptr_q != '0)); // R4
  AST_ONE_TRIAL_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ptr_q)); // R4
endmodule

// File: rtl/adc_result_flags.sv
module adc_result_flags #(
  parameter int BITS = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic            write_i,
  input  logic [BITS-1:0] code_i,
  output logic            irq_o,
  output logic [BITS-1:0] result_o
);
  logic            irq_q;
  logic [BITS-1:0] result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_q <= 1'b0;
    else if (set_i)  irq_q <= 1'b1;
    else if (clr_i)  irq_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      result_q <= '0;
    else if (write_i) result_q <= code_i;
  end

  assign irq_o    = irq_q;
  assign result_o = result_q;

  AST_IRQ_RISE_ON_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(set_i)); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !set_i && !clr_i) |=> irq_q); // R7
  AST_RESULT_ONLY_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_q) |-> $past(write_i)); // R9
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int BITS        = 10,
  parameter int MCYC_LEN    = 6,
  parameter int SAMPLE_MULT = 2,
  parameter int CONV_MULT   = 10,
  parameter int BASE_LOG2   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_wr_i,
  input  logic            div_sel_i,
  input  logic            cmp_i,
  input  logic            irq_clr_i,
  output logic            busy_o,
  output logic            irq_o,
  output logic [BITS-1:0] trial_o,
  output logic [BITS-1:0] result_o
);
  logic boundary, sar_load, sar_dec, irq_set, write_ph;
  logic [BITS-1:0] code;

  adc_mcyc_timer #(.MCYC_LEN(MCYC_LEN)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .boundary_o(boundary)
  );

  adc_phase_fsm #(
    .BITS(BITS), .SAMPLE_MULT(SAMPLE_MULT), .CONV_MULT(CONV_MULT), .BASE_LOG2(BASE_LOG2)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_wr_i), .boundary_i(boundary),
    .div_sel_i(div_sel_i), .busy_o(busy_o), .sar_load_o(sar_load),
    .sar_dec_o(sar_dec), .irq_set_o(irq_set), .write_o(write_ph)
  );

  adc_sar_reg #(.BITS(BITS)) u_sar (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(sar_load), .dec_i(sar_dec),
    .cmp_i(cmp_i), .code_o(code)
  );

  adc_result_flags #(.BITS(BITS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(irq_set), .clr_i(irq_clr_i),
    .write_i(write_ph), .code_i(code), .irq_o(irq_o), .result_o(result_o)
  );

  assign trial_o = code;

  AST_IRQ_WITH_BUSY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $fell(busy_o)); // R5
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int MCYC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       div_sel = 1'b0;
  logic       cmp;
  logic       irq_clr = 1'b0;
  logic       busy, irq;
  logic [9:0] trial, result;
  int         vin = 0;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;
  int         prev_res = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .start_wr_i(start), .div_sel_i(div_sel),
    .cmp_i(cmp), .irq_clr_i(irq_clr), .busy_o(busy), .irq_o(irq),
    .trial_o(trial), .result_o(result)
  );

  // ideal comparator model
  always_comb cmp = (vin >= int'(trial));

  function automatic int exp_len(bit d);
    return d ? 96 : 48;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobe start, return the sample count until busy is first seen high
  task automatic launch(output int n);
    @(negedge clk); start = 1'b1; n = 0;
    do begin
      @(negedge clk); start = 1'b0; n++;
    end while (!busy && n < 40);
  endtask

  // count busy cycles; optional clear in the last busy cycle, divider flip mid-run
  task automatic count_busy(input bit d, input bit clr_last, output int len);
    len = 0;
    while (busy && len < 300) begin
      len++;
      if (len == 3) div_sel = ~d;                   // R8 stimulus
      if (clr_last && len == exp_len(d)) irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
    end
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R7 irq cleared", int'(irq), 0);
  endtask

  task automatic run_conv(input int v, input bit d, input bit clr_last);
    int n, len;
    vin = v; div_sel = d;
    launch(n);
    chk("R1 start on boundary", int'(n >= 2 && n <= MCYC + 1), 1);
    count_busy(d, clr_last, len);
    chk(d ? "R3 busy length" : "R2 busy length", len, exp_len(d));
    chk("R5 irq with busy fall", int'(irq), 1);
    chk("R5 result not yet written", int'(result), prev_res);
    @(negedge clk);
    chk("R4 result code", int'(result), v);
    prev_res = v;
  endtask

  task automatic run_abort(input int v1, input int v2, input bit d, input int at);
    int n, len;
    vin = v1; div_sel = d;
    launch(n);
    repeat (at) @(negedge clk);
    start = 1'b1; vin = v2;
    @(negedge clk); start = 1'b0;
    chk("R6 busy dropped on restart", int'(busy), 0);
    chk("R6 aborted run leaves irq", int'(irq), 0);
    n = 0;
    while (!busy && n < 40) begin @(negedge clk); n++; end
    chk("R6 restart begins", int'(busy), 1);
    count_busy(d, 1'b0, len);
    chk("R6 restarted run full length", len, exp_len(d));
    chk("R6 result kept before write", int'(result), prev_res);
    @(negedge clk);
    chk("R6 restarted result", int'(result), v2);
    prev_res = v2;
    clear_irq();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    chk("R9 reset busy", int'(busy), 0);
    chk("R9 reset irq", int'(irq), 0);
    chk("R9 reset result", int'(result), 0);
    chk("R9 reset trial", int'(trial), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_conv(1023, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    chk("R7 irq sticky", int'(irq), 1);
    chk("R9 result held", int'(result), 1023);
    clear_irq();
    run_conv(0, 1'b1, 1'b0);
    clear_irq();
    run_conv(512, 1'b0, 1'b1);       // clear collides with set
    chk("R7 set wins over clear", int'(irq), 1);
    clear_irq();
    run_conv(511, 1'b1, 1'b1);
    chk("R7 set wins over clear", int'(irq), 1);
    clear_irq();
    run_abort(100, 900, 1'b0, 5);    // abort in sampling
    run_abort(700, 3, 1'b1, 40);     // abort in conversion
    run_abort(333, 666, 1'b0, 47);   // abort in last busy cycle

    // constrained random
    for (int i = 0; i < 16; i++) begin
      int v, a;
      bit d;
      v = int'($urandom % 1024);
      d = 1'($urandom % 2);
      if ($urandom % 4 == 0) begin
        a = int'($urandom % 40);
        run_abort(int'($urandom % 1024), v, d, a);
      end else begin
        run_conv(v, d, 1'b0);
        clear_irq();
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule